// File: doc/BRIEF.md
# SPI Serial Clock Generator with Two-Stage Rate Select

This block makes the serial clock for an SPI master out of the system clock. The rate comes from two select codes. A 2-bit code picks a small prime prescale factor. A 4-bit code picks a scale factor that is mostly a power of two. The SCK period, counted in system clocks, is the product of the two factors. A double-rate flag halves that count. When the halved count is odd, the two phases of SCK still differ by no more than one system clock.

The counter runs only while the enable input is high. While the enable is low, SCK rests at the polarity level. Each SCK period gives the shift engine a one-cycle leading strobe and a one-cycle trailing strobe. The rate codes and the polarity are taken when a frame starts, so a change to them during a frame has no effect until the next frame.

Top module: `spi_sck_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `sck` equal to `cpol` and both strobes low.
- R2: The prescale code `pre_sel` maps 0, 1, 2 and 3 to the factors 2, 3, 5 and 7.
- R3: The scale code `scl_sel` maps 0 to 3 to the factors 2, 4, 6 and 8, and each code c from 4 to 15 to the factor 2^c.
- R4: With `dbl_rate` low, one SCK period lasts D = prescale factor × scale factor system clocks. The first ceil(D/2) cycles are at the level opposite `cpol`, and the remaining floor(D/2) cycles are at the `cpol` level.
- R5: With `dbl_rate` high, D is half the product. When D is odd, the non-idle phase is the longer one, by exactly one cycle.
- R6: `pre_sel`, `scl_sel`, `dbl_rate` and `cpol` are sampled only at the edge where `run_en` is first seen high while idle. Changes to them during the frame leave the period, the phases and the active-level polarity unchanged.
- R7: `lead_stb` is high for exactly one cycle each time `sck` leaves the idle level, including the first cycle of a frame. `trail_stb` is high for exactly one cycle each time `sck` returns to it. The two strobes are never high together.
- R8: At the first edge where `run_en` is seen low, the next cycle shows `sck` at `cpol` with both strobes low. A later rise of `run_en` starts again from the beginning of a period.
- R9: While idle, `sck` follows `cpol` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Frame enable. High runs the clock, low stops it and clears the counter |
| cpol | input | 1 | Idle level of SCK |
| pre_sel | input | 2 | Prescale factor code |
| scl_sel | input | 4 | Scale factor code |
| dbl_rate | input | 1 | Halves the division count |
| sck | output | 1 | Serial clock, registered |
| lead_stb | output | 1 | One-cycle strobe when SCK leaves its idle level |
| trail_stb | output | 1 | One-cycle strobe when SCK returns to its idle level |

## Verification
Every output is registered, so each result appears in the cycle after the clock edge that samples its cause. The frame start, the mid-period toggle, the wrap, the stop to idle and a polarity change while idle all follow this rule. The bench drives inputs at the falling edge and updates a behavioural model at the rising edge. At the next falling edge it compares `sck` and both strobes, so model and design are always compared one edge after the stimulus. Per-frame counts of active-level cycles and strobes are then checked against closed-form expectations worked out from D. Idle level and strobes are checked one edge after `run_en` drops.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

  localparam int PRE_W = 2;
  localparam int SCL_W = 4;
  localparam int FACT_W = 16;
  localparam int PER_W = 18;

  function automatic logic [2:0] pre_factor(input logic [PRE_W-1:0] code);
    logic [2:0] f;
    case (code)
      2'd0:    f = 3'd2;
      2'd1:    f = 3'd3;
      2'd2:    f = 3'd5;
      default: f = 3'd7;
    endcase
    return f;
  endfunction

  function automatic logic [FACT_W-1:0] scl_factor(input logic [SCL_W-1:0] code);
    logic [FACT_W-1:0] f;
    if (code < SCL_W'(4))
      f = FACT_W'({code, 1'b0}) + FACT_W'(2);
    else
      f = FACT_W'(1) << code;
    return f;
  endfunction

endpackage

// File: rtl/sck_rate_sel.sv
module sck_rate_sel
  import spi_sck_pkg::*;
#(
  parameter bit DBL_EN = 1'b1
) (
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SCL_W-1:0] scl_sel,
  input  logic             dbl_rate,
  output logic [PER_W-1:0] per_len,
  output logic [PER_W-1:0] act_len
);

  logic [PER_W-1:0] prod;

  always_comb begin
    prod = PER_W'(pre_factor(pre_sel)) * PER_W'(scl_factor(scl_sel));
  end

  generate
    if (DBL_EN) begin : g_dbl
      assign per_len = dbl_rate ? (prod >> 1) : prod;
    end else begin : g_nodbl
      logic unused_dbl;
      assign unused_dbl = dbl_rate;
      assign per_len = prod;
    end
  endgenerate

  // active phase takes the extra cycle of an odd count
  assign act_len = (per_len + PER_W'(1)) >> 1;

  // R5: the phases never differ by more than one cycle
  always_comb begin
    assert ((act_len << 1) == per_len || (act_len << 1) == per_len + PER_W'(1))
      else $error("p_phase_split_r5");
  end

endmodule

// File: rtl/sck_phase_ctr.sv
module sck_phase_ctr
  import spi_sck_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [PER_W-1:0] per_len,
  input  logic [PER_W-1:0] act_len,
  output logic             start_ev,
  output logic             wrap_ev,
  output logic             half_ev
);

  logic             active;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per_q;
  logic [PER_W-1:0] act_q;
  logic [PER_W-1:0] cnt_nxt;

  assign cnt_nxt  = cnt + PER_W'(1);
  assign start_ev = run_en && !active;
  assign wrap_ev  = run_en && active && (cnt_nxt == per_q);
  assign half_ev  = run_en && active && (cnt_nxt != per_q) && (cnt_nxt == act_q);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (wrap_ev) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= PER_W'(2);
      act_q <= PER_W'(1);
    end else if (start_ev) begin
      per_q <= per_len;
      act_q <= act_len;
    end
  end

  // R6: the latched rate holds while a frame runs
  p_rate_held_r6: assert property (@(posedge clk) disable iff (rst)
    (active && run_en) |=> ($stable(per_q) && $stable(act_q)));

  // R4: the count stays inside one period
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt < per_q));

endmodule

// File: rtl/sck_pin_drv.sv
module sck_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic cpol,
  input  logic start_ev,
  input  logic wrap_ev,
  input  logic half_ev,
  output logic sck,
  output logic lead_stb,
  output logic trail_stb
);

  logic pol_q;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      sck       <= cpol;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      lead_stb  <= start_ev || wrap_ev;
      trail_stb <= half_ev;
      if (start_ev)
        sck <= !cpol;
      else if (wrap_ev)
        sck <= !pol_q;
      else if (half_ev)
        sck <= pol_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pol_q <= 1'b0;
    else if (start_ev)
      pol_q <= cpol;
  end

  // R8: a dropped enable parks the clock at the idle level one edge later
  p_idle_park_r8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (sck == $past(cpol) && !lead_stb && !trail_stb));

  // R7: the two strobes never coincide
  p_no_dual_stb_r7: assert property (@(posedge clk) disable iff (rst)
    !(lead_stb && trail_stb));

  // R7: a leading strobe comes with the non-idle level
  p_lead_level_r7: assert property (@(posedge clk) disable iff (rst)
    lead_stb |-> (sck != pol_q));

  // R7: a trailing strobe comes with the idle level
  p_trail_level_r7: assert property (@(posedge clk) disable iff (rst)
    trail_stb |-> (sck == pol_q));

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import spi_sck_pkg::*;
#(
  parameter bit DBL_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             cpol,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SCL_W-1:0] scl_sel,
  input  logic             dbl_rate,
  output logic             sck,
  output logic             lead_stb,
  output logic             trail_stb
);

  logic [PER_W-1:0] per_len;
  logic [PER_W-1:0] act_len;
  logic             start_ev;
  logic             wrap_ev;
  logic             half_ev;

  sck_rate_sel #(.DBL_EN(DBL_EN)) u_rate (
    .pre_sel  (pre_sel),
    .scl_sel  (scl_sel),
    .dbl_rate (dbl_rate),
    .per_len  (per_len),
    .act_len  (act_len)
  );

  sck_phase_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .per_len  (per_len),
    .act_len  (act_len),
    .start_ev (start_ev),
    .wrap_ev  (wrap_ev),
    .half_ev  (half_ev)
  );

  sck_pin_drv u_pin (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cpol      (cpol),
    .start_ev  (start_ev),
    .wrap_ev   (wrap_ev),
    .half_ev   (half_ev),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

endmodule

// File: tb/test_spi_sck_gen.sv
module test_spi_sck_gen;

  localparam time CLK_HALF = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic       cpol = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [3:0] scl_sel = 4'd0;
  logic       dbl_rate = 1'b0;
  logic       sck;
  logic       lead_stb;
  logic       trail_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  int pre_t [4]  = '{2, 3, 5, 7};
  int scl_t [16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                     4096, 8192, 16384, 32768};

  // behavioural reference state
  bit m_act = 0;
  int m_cnt = 0;
  int m_per = 2;
  int m_half = 1;
  bit m_pol = 0;
  bit m_sck = 0;
  bit m_lead = 0;
  bit m_trail = 0;

  spi_sck_gen i_spi_sck_gen (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cpol      (cpol),
    .pre_sel   (pre_sel),
    .scl_sel   (scl_sel),
    .dbl_rate  (dbl_rate),
    .sck       (sck),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
  );

  always #(CLK_HALF) clk = ~clk;

  function automatic int div_of(int p, int s, bit d);
    int v;
    v = pre_t[p] * scl_t[s];
    return d ? v / 2 : v;
  endfunction

  always @(posedge clk) begin
    if (rst || !run_en) begin
      m_act = 0; m_cnt = 0; m_sck = cpol; m_lead = 0; m_trail = 0;
    end else if (!m_act) begin
      m_act = 1; m_cnt = 0;
      m_per = div_of(pre_sel, scl_sel, dbl_rate);
      m_half = (m_per + 1) / 2;
      m_pol = cpol; m_sck = !cpol; m_lead = 1; m_trail = 0;
    end else begin
      m_lead = 0; m_trail = 0;
      if (m_cnt + 1 == m_per) begin
        m_cnt = 0; m_sck = !m_pol; m_lead = 1;
      end else begin
        m_cnt = m_cnt + 1;
        if (m_cnt == m_half) begin
          m_sck = m_pol; m_trail = 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(sck == m_sck, cur_tag, "sck vs model", sck, m_sck);
      chk(lead_stb == m_lead, cur_tag, "lead vs model", lead_stb, m_lead);
      chk(trail_stb == m_trail, cur_tag, "trail vs model", trail_stb, m_trail);
    end
  end

  // runs one frame of n cycles; at cycle chg_at the rate inputs are scrambled
  task automatic run_frame(int p, int s, bit d, bit pol, int n, int chg_at, string tag);
    int dv, hf, e_act, e_lead, e_trail, g_act, g_lead, g_trail;
    cur_tag = tag;
    dv = div_of(p, s, d);
    hf = (dv + 1) / 2;
    e_act = 0; e_lead = 0; e_trail = 0;
    g_act = 0; g_lead = 0; g_trail = 0;
    for (int i = 0; i < n; i++) begin
      if (i % dv < hf) e_act++;
      if (i % dv == 0) e_lead++;
      if (i % dv == hf) e_trail++;
    end
    pre_sel = p[1:0]; scl_sel = s[3:0]; dbl_rate = d; cpol = pol;
    run_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (sck != pol) g_act++;
      if (lead_stb) g_lead++;
      if (trail_stb) g_trail++;
      if (i == chg_at) begin
        pre_sel = ~pre_sel; scl_sel = 4'd0; dbl_rate = ~dbl_rate; cpol = ~cpol;
      end
    end
    chk(g_act == e_act, tag, "active-level cycles", g_act, e_act);
    chk(g_lead == e_lead, tag, "lead strobes", g_lead, e_lead);
    chk(g_trail == e_trail, tag, "trail strobes", g_trail, e_trail);
    run_en = 1'b0;
    @(posedge clk); @(negedge clk);
    // R8: idle one edge after the enable drops
    chk(sck == cpol, "R8", "idle level", sck, cpol);
    chk(!lead_stb && !trail_stb, "R8", "strobes idle", lead_stb + trail_stb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sck == 1'b0, "R1", "sck in reset", sck, 0);
    chk(!lead_stb && !trail_stb, "R1", "strobes in reset", lead_stb + trail_stb, 0);
    cpol = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(sck == 1'b1, "R1", "sck follows cpol in reset", sck, 1);
    rst = 1'b0; cpol = 1'b0;
    @(posedge clk); @(negedge clk);
    // R9: idle sck follows cpol one cycle later
    chk(sck == 1'b0, "R9", "idle sck low", sck, 0);
    cpol = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(sck == 1'b1, "R9", "idle sck high", sck, 1);

    // R2 / R4: each prescale code with scale code 0
    run_frame(0, 0, 0, 0, 9, -1, "R2");
    run_frame(1, 0, 0, 1, 14, -1, "R2");
    run_frame(2, 0, 0, 0, 23, -1, "R2");
    run_frame(3, 0, 0, 1, 31, -1, "R2");
    // R3 / R4: scale codes
    run_frame(0, 1, 0, 0, 20, -1, "R3");
    run_frame(0, 2, 0, 0, 30, -1, "R3");
    run_frame(3, 3, 0, 1, 120, -1, "R3");
    run_frame(0, 7, 0, 0, 600, -1, "R4");
    run_frame(2, 5, 0, 1, 330, -1, "R4");
    // R5: halved counts, odd and even
    run_frame(0, 0, 1, 0, 7, -1, "R5");
    run_frame(1, 0, 1, 0, 10, -1, "R5");
    run_frame(2, 0, 1, 1, 16, -1, "R5");
    run_frame(3, 0, 1, 0, 22, -1, "R5");
    run_frame(1, 2, 1, 1, 40, -1, "R5");
    run_frame(2, 5, 1, 0, 170, -1, "R5");
    // R6: inputs scrambled mid-frame
    run_frame(1, 1, 0, 0, 50, 5, "R6");
    run_frame(2, 0, 1, 1, 33, 2, "R6");
    // R7 / R8: frame cut mid-period, back-to-back restart
    run_frame(3, 1, 0, 0, 17, -1, "R7");
    run_frame(3, 1, 0, 0, 30, -1, "R8");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule